// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block takes stereo PCM audio from a three-wire serial link (bit clock, word clock, data) and turns it into pairs of 24-bit parallel samples. A static format select chooses between two framings. In I2S framing the word clock is low for the left channel and high for the right, and the MSB arrives one bit clock after the word-clock edge. In right-justified framing the polarity is the other way round, and the 16-bit word ends on the last bit clock before the word-clock edge.

The bit clock, word clock and data are oversampled in a faster system clock domain. A rising bit-clock edge is detected by comparing the current level with the previous one. Word-clock transitions are found by comparing the word-clock level at each bit-clock rise with the level latched at the rise before. Short I2S words are left-aligned with zeros below them. When both halves of a frame last exactly 16 bit clocks, the frame is flagged as packed 16-bit.

A three-state machine frames the stream. SYNC waits after reset until the word clock enters the left-channel level. LEFT receives the left word; its edge stores that word and moves to RIGHT. RIGHT receives the right word; its edge publishes the pair with a one-cycle strobe and returns to LEFT.

Top module: `dual_format_audio_rx`

## Requirements
- R1: With `fmt_i2s`=1 the word clock is low for the left channel and high for the right. The MSB is captured on the second bit-clock rise after a word-clock change, and later bits follow MSB first on the next rises.
- R2: With `fmt_i2s`=1, bits beyond the 24th of a word are ignored, so a 32-bit word yields its top 24 bits.
- R3: With `fmt_i2s`=1, a word of N<24 bits in a half of N bit clocks appears in bits 23..24-N, with the low 24-N bits zero.
- R4: When both halves of a frame last exactly 16 bit clocks, `packed16_o`=1 with that pair and bits 7..0 of both samples are 0. Otherwise `packed16_o`=0.
- R5: With `fmt_i2s`=0 the word clock is high for the left channel and low for the right. The last 16 data bits before each word-clock change form the word, with its LSB taken on the final rise before the change. The word is output in bits 23..8, and bits 7..0 are zero. Earlier bits in the half are ignored.
- R6: `pair_valid_o` pulses for exactly one system clock after the right word of a frame completes. `left_o`, `right_o` and `packed16_o` change only with that pulse and hold until the next one.
- R7: After reset all outputs are 0. The half in progress when sampling starts is discarded, and the first pair is the first left half that begins with a word-clock change, followed by its right half.
- R8: Unequal left and right half lengths are accepted, as long as each half holds at least the word length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than four times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_i2s | input | 1 | 1: I2S framing, 0: right-justified 16-bit framing (static) |
| bck_i | input | 1 | Serial bit clock |
| ws_i | input | 1 | Word clock (channel select) |
| sd_i | input | 1 | Serial data |
| left_o | output | 24 | Left sample, left-aligned |
| right_o | output | 24 | Right sample, left-aligned |
| pair_valid_o | output | 1 | One-cycle strobe when a new pair is presented |
| packed16_o | output | 1 | Pair came from a frame of two 16-bit-clock halves |

## Verification
The assertions check on every cycle that the strobe is one cycle wide and follows a detected word-clock change, and that the samples never move outside a strobe. They also check that the low byte is clear for right-justified and packed-16 pairs. Which bits end up in a word cannot be checked that way. Only the bench scenarios show this: MSB position, truncation beyond 24 bits, zero padding, alignment at the end of a right-justified half, channel polarity, discarding of the first partial half, and the packed-16 decision for uneven halves. In each scenario the bench compares every strobed pair against a reference built from the serial stream it sent.

// File: rtl/dfar_pkg.sv
package dfar_pkg;
    typedef enum logic [1:0] {
        ST_SYNC  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } dfar_state_t;
endpackage

// File: rtl/dfar_sampler.sv
module dfar_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic bck_i,
    input  logic ws_i,
    input  logic sd_i,
    output logic rise_o,
    output logic ws_o,
    output logic sd_o,
    output logic edge_o
);
    logic s_bck, s_ws, s_sd, bck_q, ws_prev, primed;

    assign rise_o = s_bck & ~bck_q;
    assign ws_o   = s_ws;
    assign sd_o   = s_sd;
    assign edge_o = rise_o & primed & (s_ws != ws_prev);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_bck   <= 1'b0;
            s_ws    <= 1'b0;
            s_sd    <= 1'b0;
            bck_q   <= 1'b0;
            ws_prev <= 1'b0;
            primed  <= 1'b0;
        end else begin
            s_bck <= bck_i;
            s_ws  <= ws_i;
            s_sd  <= sd_i;
            bck_q <= s_bck;
            if (rise_o) begin
                ws_prev <= s_ws;
                primed  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dfar_word_asm.sv
module dfar_word_asm #(
    parameter int SAMPLE_W = 24,
    parameter int RJ_W     = 16,
    parameter int CNT_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rise_i,
    input  logic                edge_i,
    input  logic                sd_i,
    input  logic                fmt_i2s,
    output logic [SAMPLE_W-1:0] word_o,
    output logic [CNT_W:0]      len_o
);
    localparam int PAD_W = SAMPLE_W - RJ_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0]    cnt;
    logic [CNT_W:0]      pos;
    logic [SAMPLE_W-1:0] acc, acc_next;
    logic [RJ_W-1:0]     tail;

    // position of the bit taken at this rise, counted from the last edge
    assign pos   = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
    assign len_o = pos;

    always_comb begin
        acc_next = acc;
        for (int i = 0; i < SAMPLE_W; i++) begin
            if (int'(pos) == SAMPLE_W - i) acc_next[i] = sd_i;
        end
    end

    assign word_o = fmt_i2s ? acc_next : {tail, {PAD_W{1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            acc  <= '0;
            tail <= '0;
        end else if (rise_i) begin
            tail <= {tail[RJ_W-2:0], sd_i};
            if (edge_i) begin
                acc <= '0;
                cnt <= '0;
            end else begin
                acc <= acc_next;
                cnt <= (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dfar_frame_fsm.sv
module dfar_frame_fsm
    import dfar_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int RJ_W     = 16,
    parameter int CNT_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                edge_i,
    input  logic                ws_i,
    input  logic                fmt_i2s,
    input  logic [SAMPLE_W-1:0] word_i,
    input  logic [CNT_W:0]      len_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o,
    output logic                pk16_o
);
    dfar_state_t         state_q, state_d;
    logic [SAMPLE_W-1:0] hold_l;
    logic                hold16;
    logic                left_lvl;
    logic                half16;

    assign left_lvl = ~fmt_i2s;
    assign half16   = (int'(len_i) == RJ_W);

    always_comb begin
        state_d = state_q;
        if (edge_i) begin
            unique case (state_q)
                ST_SYNC:  if (ws_i == left_lvl) state_d = ST_LEFT;
                ST_LEFT:  state_d = ST_RIGHT;
                ST_RIGHT: state_d = ST_LEFT;
                default:  state_d = ST_SYNC;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SYNC;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_l  <= '0;
            hold16  <= 1'b0;
            left_o  <= '0;
            right_o <= '0;
            valid_o <= 1'b0;
            pk16_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (edge_i) begin
                unique case (state_q)
                    ST_LEFT: begin
                        hold_l <= word_i;
                        hold16 <= half16;
                    end
                    ST_RIGHT: begin
                        left_o  <= hold_l;
                        right_o <= word_i;
                        pk16_o  <= hold16 & half16;
                        valid_o <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dual_format_audio_rx.sv
module dual_format_audio_rx #(
    parameter int SAMPLE_W = 24,
    parameter int RJ_W     = 16,
    parameter int CNT_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fmt_i2s,
    input  logic                bck_i,
    input  logic                ws_i,
    input  logic                sd_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                pair_valid_o,
    output logic                packed16_o
);
    logic                bit_rise, ws_lvl, sd_bit, frame_edge;
    logic [SAMPLE_W-1:0] word;
    logic [CNT_W:0]      len;

    dfar_sampler u_smp (
        .clk    (clk),
        .rst_n  (rst_n),
        .bck_i  (bck_i),
        .ws_i   (ws_i),
        .sd_i   (sd_i),
        .rise_o (bit_rise),
        .ws_o   (ws_lvl),
        .sd_o   (sd_bit),
        .edge_o (frame_edge)
    );

    dfar_word_asm #(.SAMPLE_W(SAMPLE_W), .RJ_W(RJ_W), .CNT_W(CNT_W)) u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (bit_rise),
        .edge_i  (frame_edge),
        .sd_i    (sd_bit),
        .fmt_i2s (fmt_i2s),
        .word_o  (word),
        .len_o   (len)
    );

    dfar_frame_fsm #(.SAMPLE_W(SAMPLE_W), .RJ_W(RJ_W), .CNT_W(CNT_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .edge_i  (frame_edge),
        .ws_i    (ws_lvl),
        .fmt_i2s (fmt_i2s),
        .word_i  (word),
        .len_i   (len),
        .left_o  (left_o),
        .right_o (right_o),
        .valid_o (pair_valid_o),
        .pk16_o  (packed16_o)
    );
endmodule

// File: rtl/dfar_checker.sv
module dfar_checker #(
    parameter int SAMPLE_W = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic                fmt_i2s,
    input logic                frame_edge,
    input logic [SAMPLE_W-1:0] left_o,
    input logic [SAMPLE_W-1:0] right_o,
    input logic                pair_valid_o,
    input logic                packed16_o
);
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid_o |=> !pair_valid_o);

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid_o |-> ($stable(left_o) && $stable(right_o) && $stable(packed16_o)));

    a_r6_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid_o |-> $past(frame_edge));

    a_r5_rj_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid_o && !fmt_i2s) |-> (left_o[7:0] == 8'h00 && right_o[7:0] == 8'h00));

    a_r4_packed_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid_o && packed16_o) |-> (left_o[7:0] == 8'h00 && right_o[7:0] == 8'h00));
endmodule

bind dual_format_audio_rx dfar_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fmt_i2s      (fmt_i2s),
    .frame_edge   (frame_edge),
    .left_o       (left_o),
    .right_o      (right_o),
    .pair_valid_o (pair_valid_o),
    .packed16_o   (packed16_o)
);

// File: tb/dual_format_audio_rx_test.sv
module dual_format_audio_rx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fmt_i2s = 1'b1;
    logic        bck = 1'b0, ws = 1'b0, sd = 1'b0;
    logic [23:0] left_o, right_o;
    logic        pair_valid_o, packed16_o;

    int total = 0, fails = 0;
    int hold_err = 0, dbl_err = 0;
    string cur_tag = "R1";

    logic [23:0] exp_l[$], exp_r[$];
    bit          exp_p[$];
    logic [23:0] last_l = '0, last_r = '0;
    bit          last_p = 1'b0, prev_v = 1'b0;

    always #2 clk = ~clk;

    dual_format_audio_rx uut (
        .clk(clk), .rst_n(rst_n), .fmt_i2s(fmt_i2s),
        .bck_i(bck), .ws_i(ws), .sd_i(sd),
        .left_o(left_o), .right_o(right_o),
        .pair_valid_o(pair_valid_o), .packed16_o(packed16_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // per-clock monitor against the expected-pair queue
    always @(negedge clk) begin
        if (!rst_n) begin
            last_l = '0; last_r = '0; last_p = 1'b0; prev_v = 1'b0;
        end else begin
            if (pair_valid_o) begin
                if (prev_v) dbl_err++;
                if (exp_l.size() == 0) begin
                    chk(1'b0, "R7", "unexpected pair", {8'h0, left_o}, 32'h0);
                end else begin
                    logic [23:0] el, er; bit ep;
                    el = exp_l.pop_front(); er = exp_r.pop_front(); ep = exp_p.pop_front();
                    chk(left_o == el, cur_tag, "left sample", {8'h0, left_o}, {8'h0, el});
                    chk(right_o == er, cur_tag, "right sample", {8'h0, right_o}, {8'h0, er});
                    chk(packed16_o == ep, "R4", "packed16 flag", {31'h0, packed16_o}, {31'h0, ep});
                end
                last_l = left_o; last_r = right_o; last_p = packed16_o;
            end else if (left_o != last_l || right_o != last_r || packed16_o != last_p) begin
                hold_err++;
            end
            prev_v = pair_valid_o;
        end
    end

    function automatic logic [23:0] exp_i2s(input logic [31:0] w, input int wl);
        if (wl >= 24) return 24'(w >> (wl - 24));
        return 24'(w << (24 - wl));
    endfunction

    task automatic run_stream(input bit fmt, input int nl, input int nr,
                              input int wl, input int np, input string tag);
        bit          wsq[$], sdq[$];
        int          st_l[$], st_r[$];
        bit          lft, rgt;
        logic [31:0] lw, rw;
        lft = fmt ? 1'b0 : 1'b1;
        rgt = ~lft;
        cur_tag = tag;
        // reset and check idle outputs
        @(negedge clk);
        rst_n = 1'b0; bck = 1'b0; fmt_i2s = fmt; hold_err = 0; dbl_err = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pair_valid_o == 1'b0, "R7", "valid after reset", {31'h0, pair_valid_o}, 32'h0);
        chk(left_o == 0 && right_o == 0 && packed16_o == 0, "R7", "samples after reset",
            {8'h0, left_o}, 32'h0);
        // partial half at the right-channel level, then full frames
        for (int i = 0; i < 5; i++) begin wsq.push_back(rgt); sdq.push_back(1'($urandom)); end
        for (int p = 0; p < np; p++) begin
            st_l.push_back(wsq.size());
            for (int i = 0; i < nl; i++) begin
                wsq.push_back(lft); sdq.push_back(fmt ? 1'b0 : 1'($urandom));
            end
            st_r.push_back(wsq.size());
            for (int i = 0; i < nr; i++) begin
                wsq.push_back(rgt); sdq.push_back(fmt ? 1'b0 : 1'($urandom));
            end
        end
        for (int i = 0; i < 4; i++) begin wsq.push_back(lft); sdq.push_back(1'b0); end
        for (int p = 0; p < np; p++) begin
            lw = $urandom; rw = $urandom;
            if (fmt) begin
                if (wl < 32) begin
                    lw = lw & ((32'h1 << wl) - 1);
                    rw = rw & ((32'h1 << wl) - 1);
                end
                for (int b = 0; b < wl; b++) begin
                    sdq[st_l[p] + 1 + b] = lw[wl - 1 - b];
                    sdq[st_r[p] + 1 + b] = rw[wl - 1 - b];
                end
                exp_l.push_back(exp_i2s(lw, wl));
                exp_r.push_back(exp_i2s(rw, wl));
            end else begin
                for (int b = 0; b < 16; b++) begin
                    sdq[st_l[p] + nl - 16 + b] = lw[15 - b];
                    sdq[st_r[p] + nr - 16 + b] = rw[15 - b];
                end
                exp_l.push_back({lw[15:0], 8'h00});
                exp_r.push_back({rw[15:0], 8'h00});
            end
            exp_p.push_back(nl == 16 && nr == 16);
        end
        // play: two system clocks low, two high per bit
        for (int i = 0; i < wsq.size(); i++) begin
            bck = 1'b0; ws = wsq[i]; sd = sdq[i];
            repeat (2) @(negedge clk);
            bck = 1'b1;
            repeat (2) @(negedge clk);
        end
        bck = 1'b0;
        repeat (20) @(negedge clk);
        chk(exp_l.size() == 0, tag, "pairs still expected", exp_l.size(), 32'h0);
        chk(hold_err == 0, "R6", "outputs moved without strobe", hold_err, 32'h0);
        chk(dbl_err == 0, "R6", "strobe longer than one cycle", dbl_err, 32'h0);
        exp_l.delete(); exp_r.delete(); exp_p.delete();
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        run_stream(1'b1, 24, 24, 24, 3, "R1");  // R1 MSB on second rise, ws low = left
        run_stream(1'b1, 32, 32, 32, 3, "R2");  // R2 bits past 24 dropped
        run_stream(1'b1, 20, 20, 20, 2, "R3");  // R3 zero padding of short words
        run_stream(1'b1, 16, 16, 16, 3, "R4");  // R4 packed 16-bit frames
        run_stream(1'b1, 16, 24, 16, 2, "R8");  // R8 uneven halves, not packed
        run_stream(1'b0, 16, 16, 16, 3, "R5");  // R5 right-justified packed
        run_stream(1'b0, 32, 20, 16, 2, "R5");  // R5 and R8 uneven right-justified
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule